// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the addressing-mode field of an instruction into the memory, I/O or immediate operand that the instruction needs, in a 16-bit accumulator CPU. The core presents a request together with a 3-bit mode code, the 16-bit operand word, the base/index register B and the 12-bit stack registers SP and FP. The block answers with exactly one of four registered strobes: a memory access at a 16-bit word address, an I/O access at an 8-bit port, an immediate value, or nothing when the operand is a register.

Word addresses cover 64K words with no paging, and every sum wraps. The stack lives in the top 4K words. A stack-relative address is formed by adding the operand's low 12 bits to SP or FP modulo 4096 and placing four ones above the result. An indirect operand needs a second memory read. The block first issues a pointer read at the operand address, then waits for the returned word, and then issues that word as the effective address. Control-transfer instructions may not use a stack-relative mode. Such a request is answered with an illegal-mode flag and no access.

Top module: `opnd_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, all strobes (`done`, `mem_req`, `ptr_req`, `io_req`, `imm_valid`, `illegal`) and `busy` are low.
- R2: Mode 3'd1 (direct): the cycle after an accepted request, `mem_req` and `done` are high with `mem_addr` equal to the operand word.
- R3: Mode 3'd3 (indexed): `mem_req` and `done` are high with `mem_addr` = (B + operand) mod 65536.
- R4: Mode 3'd5 (frame-relative): `mem_req` and `done` are high with `mem_addr` = {4'b1111, (FP + operand[11:0]) mod 4096}.
- R5: Mode 3'd7 (stack-pointer-relative): same as R4 but using SP in place of FP.
- R6: Mode 3'd4 (immediate): `imm_valid` and `done` are high, `imm_data` equals the operand word, and no memory or I/O strobe is raised.
- R7: Mode 3'd0 (register): `done` is high and no access strobe is raised.
- R8: Mode 3'd6 (I/O port): `io_req` and `done` are high, `io_addr` equals operand[7:0], and `mem_req` stays low.
- R9: Mode 3'd2 (indirect): the cycle after the request, `ptr_req` is high with `mem_addr` equal to the operand, and `busy` is high. The cycle after `ptr_valid` is seen, `mem_req` and `done` are high with `mem_addr` equal to `ptr_data`, and `busy` is low.
- R10: With `is_xfer` high, modes 3'd5 and 3'd7 give `done` and `illegal` high and raise no access strobe.
- R11: With `is_xfer` high, every other mode behaves as it does without it, and `illegal` stays low.
- R12: While `busy` is high, new requests are ignored: they produce no strobe and do not disturb the pending indirect fetch.
- R13: Each strobe lasts one cycle, and at most one of `mem_req`, `ptr_req`, `io_req` and `imm_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Operand request from the core |
| mode | input | 3 | Addressing-mode code |
| is_xfer | input | 1 | Request belongs to a jump, branch or call |
| operand | input | 16 | Instruction operand word |
| reg_b | input | 16 | Base/index register value |
| reg_sp | input | 12 | Stack pointer value |
| reg_fp | input | 12 | Frame pointer value |
| ptr_valid | input | 1 | Pointer word returned by memory |
| ptr_data | input | 16 | Returned pointer word |
| done | output | 1 | Result strobe for the request |
| mem_req | output | 1 | Memory access at `mem_addr` |
| ptr_req | output | 1 | Pointer read at `mem_addr` (indirect first step) |
| mem_addr | output | 16 | Word address |
| io_req | output | 1 | I/O access at `io_addr` |
| io_addr | output | 8 | I/O port number |
| imm_valid | output | 1 | Immediate value available |
| imm_data | output | 16 | Immediate value |
| illegal | output | 1 | Stack mode requested by a control transfer |
| busy | output | 1 | Indirect fetch pending |

## Verification
Several properties are checked on every cycle. At most one access strobe is high at a time. An illegal answer never carries an access. A frame or stack address always lands in the top window. A returned pointer becomes the next address, and a busy cycle never starts a new access. The arithmetic values for each mode are shown only by the bench's scenarios. These are the wrap-around sums for indexed and stack offsets, the pass-through of immediates and port numbers, and the ordering of the two-step indirect exchange when requests arrive in the middle of it.

// File: rtl/opnd_addr_pkg.sv
// Shared encodings for the operand address generator.
// Assumes the mode field is three bits wide and fully decoded.
package opnd_addr_pkg;

    typedef enum logic [2:0] {
        MD_REG   = 3'd0,
        MD_DIR   = 3'd1,
        MD_IND   = 3'd2,
        MD_IDX   = 3'd3,
        MD_IMM   = 3'd4,
        MD_FRAME = 3'd5,
        MD_IO    = 3'd6,
        MD_STACK = 3'd7
    } mode_e;

    // Kind of answer a request produces
    typedef enum logic [2:0] {
        CL_NONE = 3'd0,
        CL_MEM  = 3'd1,
        CL_PTR  = 3'd2,
        CL_IO   = 3'd3,
        CL_IMM  = 3'd4,
        CL_BAD  = 3'd5
    } class_e;

    // Which sum feeds the address output
    typedef enum logic [1:0] {
        SRC_OPND  = 2'd0,
        SRC_INDEX = 2'd1,
        SRC_FRAME = 2'd2,
        SRC_STACK = 2'd3
    } src_e;

endpackage

// File: rtl/ea_mode_decode.sv
// Mode decoder: maps a mode code and the control-transfer flag to the
// kind of answer and the address source. Purely combinational.
// Assumes all eight codes are defined; stack modes are illegal for transfers.
module ea_mode_decode
    import opnd_addr_pkg::*;
(
    input  mode_e  mode,
    input  logic   is_xfer,
    output class_e cls,
    output src_e   src
);

    // Classify the request and pick the address sum
    always_comb begin
        cls = CL_NONE;
        src = SRC_OPND;
        unique case (mode)
            MD_REG:   cls = CL_NONE;
            MD_DIR:   cls = CL_MEM;
            MD_IND:   cls = CL_PTR;
            MD_IDX: begin
                cls = CL_MEM;
                src = SRC_INDEX;
            end
            MD_IMM:   cls = CL_IMM;
            MD_FRAME: begin
                cls = is_xfer ? CL_BAD : CL_MEM;
                src = SRC_FRAME;
            end
            MD_IO:    cls = CL_IO;
            MD_STACK: begin
                cls = is_xfer ? CL_BAD : CL_MEM;
                src = SRC_STACK;
            end
            default:  cls = CL_NONE;
        endcase
    end

endmodule

// File: rtl/ea_addr_calc.sv
// Address arithmetic: computes base+displacement and stack-window sums.
// Assumes STK_W <= AW; stack sums wrap inside STK_W bits and the bits
// above are forced to one, placing the stack at the top of memory.
module ea_addr_calc
    import opnd_addr_pkg::*;
#(
    parameter int AW    = 16,
    parameter int STK_W = 12
) (
    input  logic [AW-1:0]    operand,
    input  logic [AW-1:0]    reg_b,
    input  logic [STK_W-1:0] reg_sp,
    input  logic [STK_W-1:0] reg_fp,
    input  src_e             src,
    output logic [AW-1:0]    addr
);

    localparam int HI_W = AW - STK_W;

    logic [AW-1:0]    idx_sum;
    logic [STK_W-1:0] frame_off;
    logic [STK_W-1:0] stack_off;
    logic [AW-1:0]    frame_addr;
    logic [AW-1:0]    stack_addr;

    // Wrapping sums for indexed and stack-relative forms
    always_comb begin
        idx_sum   = reg_b + operand;
        frame_off = reg_fp + operand[STK_W-1:0];
        stack_off = reg_sp + operand[STK_W-1:0];
    end

    generate
        if (HI_W > 0) begin : g_window
            // Place stack offsets under an all-ones prefix
            always_comb begin
                frame_addr = {{HI_W{1'b1}}, frame_off};
                stack_addr = {{HI_W{1'b1}}, stack_off};
            end
        end else begin : g_flat
            // Stack spans the whole space
            always_comb begin
                frame_addr = frame_off;
                stack_addr = stack_off;
            end
        end
    endgenerate

    // Select the sum the decoder asked for
    always_comb begin
        unique case (src)
            SRC_INDEX: addr = idx_sum;
            SRC_FRAME: addr = frame_addr;
            SRC_STACK: addr = stack_addr;
            default:   addr = operand;
        endcase
    end

endmodule

// File: rtl/ea_ind_seq.sv
// Indirect fetch sequencer: holds the block busy from the pointer read
// until the pointer word returns. Assumes memory answers with a
// single-cycle ptr_valid pulse; synchronous active-low reset.
module ea_ind_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ptr_valid,
    output logic busy,
    output logic fire
);

    typedef enum logic {ST_IDLE, ST_WAIT} st_e;
    st_e state;

    // Advance between idle and pointer-wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (state == ST_IDLE && start) begin
            state <= ST_WAIT;
        end else if (state == ST_WAIT && ptr_valid) begin
            state <= ST_IDLE;
        end
    end

    // Expose the wait state and the pointer acceptance
    always_comb begin
        busy = (state == ST_WAIT);
        fire = (state == ST_WAIT) && ptr_valid;
    end

    // R9: a start from idle leads to a busy cycle
    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> busy);

    // R12: a further start while waiting does not restart the sequence
    p_wait_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ptr_valid) |=> busy);

endmodule

// File: rtl/opnd_addr_gen.sv
// Operand effective address generator for a 16-bit accumulator CPU.
// Decodes the mode, forms the address, runs the two-step indirect fetch
// and registers one result strobe per request. Requests are ignored
// while an indirect fetch is pending. Synchronous active-low reset.
module opnd_addr_gen
    import opnd_addr_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int STK_W = 12,
    parameter int IO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       mode,
    input  logic             is_xfer,
    input  logic [DW-1:0]    operand,
    input  logic [AW-1:0]    reg_b,
    input  logic [STK_W-1:0] reg_sp,
    input  logic [STK_W-1:0] reg_fp,
    input  logic             ptr_valid,
    input  logic [AW-1:0]    ptr_data,
    output logic             done,
    output logic             mem_req,
    output logic             ptr_req,
    output logic [AW-1:0]    mem_addr,
    output logic             io_req,
    output logic [IO_W-1:0]  io_addr,
    output logic             imm_valid,
    output logic [DW-1:0]    imm_data,
    output logic             illegal,
    output logic             busy
);

    localparam int HI_W = AW - STK_W;

    class_e        cls;
    src_e          src;
    logic [AW-1:0] calc_addr;
    logic          accept;
    logic          fire;
    logic          seq_start;

    ea_mode_decode u_decode (
        .mode    (mode_e'(mode)),
        .is_xfer (is_xfer),
        .cls     (cls),
        .src     (src)
    );

    ea_addr_calc #(.AW(AW), .STK_W(STK_W)) u_calc (
        .operand (operand[AW-1:0]),
        .reg_b   (reg_b),
        .reg_sp  (reg_sp),
        .reg_fp  (reg_fp),
        .src     (src),
        .addr    (calc_addr)
    );

    // Requests are taken only when no indirect fetch is pending
    always_comb begin
        accept    = req_valid && !busy;
        seq_start = accept && (cls == CL_PTR);
    end

    ea_ind_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (seq_start),
        .ptr_valid (ptr_valid),
        .busy      (busy),
        .fire      (fire)
    );

    // Register one result per accepted request or returned pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            mem_req   <= 1'b0;
            ptr_req   <= 1'b0;
            io_req    <= 1'b0;
            imm_valid <= 1'b0;
            illegal   <= 1'b0;
            mem_addr  <= '0;
            io_addr   <= '0;
            imm_data  <= '0;
        end else begin
            done      <= 1'b0;
            mem_req   <= 1'b0;
            ptr_req   <= 1'b0;
            io_req    <= 1'b0;
            imm_valid <= 1'b0;
            illegal   <= 1'b0;
            if (fire) begin
                mem_req  <= 1'b1;
                done     <= 1'b1;
                mem_addr <= ptr_data;
            end else if (accept) begin
                unique case (cls)
                    CL_MEM: begin
                        mem_req  <= 1'b1;
                        done     <= 1'b1;
                        mem_addr <= calc_addr;
                    end
                    CL_PTR: begin
                        ptr_req  <= 1'b1;
                        mem_addr <= calc_addr;
                    end
                    CL_IO: begin
                        io_req  <= 1'b1;
                        done    <= 1'b1;
                        io_addr <= operand[IO_W-1:0];
                    end
                    CL_IMM: begin
                        imm_valid <= 1'b1;
                        done      <= 1'b1;
                        imm_data  <= operand;
                    end
                    CL_BAD: begin
                        illegal <= 1'b1;
                        done    <= 1'b1;
                    end
                    default: done <= 1'b1;
                endcase
            end
        end
    end

    // R13: access strobes never overlap
    p_one_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, ptr_req, io_req, imm_valid}));

    // R10: an illegal answer completes without any access
    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !mem_req && !ptr_req && !io_req && !imm_valid));

    // R4: a frame or stack access lands in the top window
    p_stack_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(accept && !is_xfer && (mode == MD_FRAME || mode == MD_STACK)))
            |-> (mem_addr[AW-1:AW-HI_W] == {HI_W{1'b1}}));

    // R9: the returned pointer becomes the next access address
    p_ptr_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (mem_req && done && mem_addr == $past(ptr_data)));

    // R12: a busy cycle never starts a new non-memory answer
    p_busy_ignores_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!ptr_req && !io_req && !imm_valid && !illegal));

    // R6: immediate data equals the operand of the previous cycle
    p_imm_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        imm_valid |-> (imm_data == $past(operand)));

endmodule

// File: tb/opnd_addr_gen_bench.sv
module opnd_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        is_xfer = 1'b0;
    logic [15:0] operand = '0;
    logic [15:0] reg_b = '0;
    logic [11:0] reg_sp = '0;
    logic [11:0] reg_fp = '0;
    logic        ptr_valid = 1'b0;
    logic [15:0] ptr_data = '0;
    logic        done, mem_req, ptr_req, io_req, imm_valid, illegal, busy;
    logic [15:0] mem_addr, imm_data;
    logic [7:0]  io_addr;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    opnd_addr_gen u_opnd_addr_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .is_xfer(is_xfer), .operand(operand), .reg_b(reg_b),
        .reg_sp(reg_sp), .reg_fp(reg_fp), .ptr_valid(ptr_valid),
        .ptr_data(ptr_data), .done(done), .mem_req(mem_req),
        .ptr_req(ptr_req), .mem_addr(mem_addr), .io_req(io_req),
        .io_addr(io_addr), .imm_valid(imm_valid), .imm_data(imm_data),
        .illegal(illegal), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_addr(input int md, input logic [15:0] op,
                                             input logic [15:0] b, input logic [11:0] fp,
                                             input logic [11:0] sp);
        logic [11:0] s;
        case (md)
            3: exp_addr = b + op;
            5: begin s = fp + op[11:0]; exp_addr = {4'hF, s}; end
            7: begin s = sp + op[11:0]; exp_addr = {4'hF, s}; end
            default: exp_addr = op;
        endcase
    endfunction

    // strobes packed: {done, mem_req, ptr_req, io_req, imm_valid, illegal}
    function automatic logic [5:0] strobes();
        strobes = {done, mem_req, ptr_req, io_req, imm_valid, illegal};
    endfunction

    task automatic run_one(input int md, input bit xf, input logic [15:0] op,
                           input logic [15:0] b, input logic [11:0] fp,
                           input logic [11:0] sp, input logic [15:0] pd);
        @(negedge clk);
        req_valid = 1'b1; mode = md[2:0]; is_xfer = xf; operand = op;
        reg_b = b; reg_fp = fp; reg_sp = sp;
        @(negedge clk);
        req_valid = 1'b0;
        if (xf && (md == 5 || md == 7)) begin
            chk("R10 illegal strobes", strobes(), 6'b100001);
        end else begin
            if (xf) chk("R11 illegal low on transfer", illegal, 1'b0);
            case (md)
                0: chk("R7 register strobes", strobes(), 6'b100000);
                1: begin chk("R2 direct strobes", strobes(), 6'b110000);
                         chk("R2 direct addr", mem_addr, exp_addr(md, op, b, fp, sp)); end
                3: begin chk("R3 indexed strobes", strobes(), 6'b110000);
                         chk("R3 indexed addr", mem_addr, exp_addr(md, op, b, fp, sp)); end
                5: begin chk("R4 frame strobes", strobes(), 6'b110000);
                         chk("R4 frame addr", mem_addr, exp_addr(md, op, b, fp, sp)); end
                7: begin chk("R5 stack strobes", strobes(), 6'b110000);
                         chk("R5 stack addr", mem_addr, exp_addr(md, op, b, fp, sp)); end
                4: begin chk("R6 imm strobes", strobes(), 6'b100010);
                         chk("R6 imm data", imm_data, op); end
                6: begin chk("R8 io strobes", strobes(), 6'b100100);
                         chk("R8 io addr", io_addr, op[7:0]); end
                default: begin
                    chk("R9 ptr strobes", strobes(), 6'b001000);
                    chk("R9 ptr addr", mem_addr, op);
                    chk("R9 busy during wait", busy, 1'b1);
                    ptr_valid = 1'b1; ptr_data = pd;
                    @(negedge clk);
                    ptr_valid = 1'b0;
                    chk("R9 final strobes", strobes(), 6'b110000);
                    chk("R9 final addr", mem_addr, pd);
                    chk("R9 busy cleared", busy, 1'b0);
                end
            endcase
        end
        @(negedge clk);
        chk("R13 strobes one cycle", strobes(), 6'b000000);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", {strobes(), busy}, 7'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {strobes(), busy}, 7'b0);

        // Directed corners: wrap of sums and stack window edges
        run_one(3, 0, 16'hFFFF, 16'h0002, 12'h000, 12'h000, 16'h0);
        run_one(5, 0, 16'h0005, 16'h0000, 12'hFFE, 12'h000, 16'h0);
        run_one(7, 0, 16'hA001, 16'h0000, 12'h000, 12'hFFF, 16'h0);
        run_one(1, 0, 16'h0000, 16'h0000, 12'h000, 12'h000, 16'h0);
        run_one(6, 0, 16'h12FE, 16'h0000, 12'h000, 12'h000, 16'h0);
        run_one(4, 1, 16'hBEEF, 16'h0000, 12'h000, 12'h000, 16'h0);
        run_one(5, 1, 16'h0001, 16'h0000, 12'h100, 12'h000, 16'h0);
        run_one(7, 1, 16'h0001, 16'h0000, 12'h000, 12'h200, 16'h0);
        run_one(2, 1, 16'h0010, 16'h0000, 12'h000, 12'h000, 16'hF00D);

        // R12: requests during a pending indirect fetch are ignored
        @(negedge clk);
        req_valid = 1'b1; mode = 3'd2; is_xfer = 1'b0; operand = 16'h0040;
        @(negedge clk);
        mode = 3'd6; operand = 16'h0077;
        chk("R12 ptr issued", ptr_req, 1'b1);
        @(negedge clk);
        mode = 3'd4;
        chk("R12 no strobe while busy", strobes(), 6'b000000);
        chk("R12 still busy", busy, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 no strobe while busy 2", strobes(), 6'b000000);
        ptr_valid = 1'b1; ptr_data = 16'h1234;
        @(negedge clk);
        ptr_valid = 1'b0;
        chk("R12 fetch completes", strobes(), 6'b110000);
        chk("R12 fetch addr", mem_addr, 16'h1234);
        @(negedge clk);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            run_one(int'($urandom_range(0, 7)), bit'($urandom_range(0, 1)),
                    16'($urandom), 16'($urandom), 12'($urandom),
                    12'($urandom), 16'($urandom));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog ends a hung run as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule